// File: doc/BRIEF.md
# Addressed-Frame Serial Receiver

This block receives asynchronous serial frames on a single line. Each frame carries eight payload bits plus one extra flag bit that marks the frame as either a station address (flag 1) or payload (flag 0). Several receivers can therefore share one line, and each one accepts only the payload that follows its own address.

Software arms an address filter with a one-cycle strobe. While the filter is armed, the hardware discards payload frames without touching any status flag. The first address frame is loaded normally, and the filter disarms itself. Software then reads the address and compares it with its own station number. On a mismatch it clears the ready flag and re-arms the filter. On a match it clears the ready flag and keeps collecting payload frames.

The receiver reports overrun and framing errors. While either error flag is set, reception stops completely. A synchronised copy of the line level is exported, so that after a framing error software can tell a held-low break from a corrupted frame. The bit clock comes from a fixed divider that feeds a 16x oversampling counter.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `en`, `id_wait`, `ready`, `ovr_err`, `frm_err`, `rx_flag` and `rx_byte` are all 0.
- R2: A frame has this layout, sent least significant bit first: a low start bit, 8 payload bits, 1 flag bit, and a high stop bit. Each bit lasts 16*DIV clocks. With `en`=1, `id_wait`=0 and no flag set, a complete frame loads the payload into `rx_byte` and the flag bit into `rx_flag`, and it sets `ready`.
- R3: While `id_wait`=1, a frame whose flag bit is 0 leaves `ready`, `ovr_err`, `frm_err`, `rx_byte` and `rx_flag` unchanged.
- R4: While `id_wait`=1, a frame whose flag bit is 1 is loaded as in R2, and `id_wait` returns to 0.
- R5: If a frame completes while `ready`=1, `ovr_err` is set, and `rx_byte` and `ready` keep their earlier values.
- R6: A frame whose stop bit is sampled low sets `frm_err` and leaves `rx_byte` and `ready` unchanged.
- R7: While `ovr_err` or `frm_err` is 1, frames on the line change no output. Reception resumes once both flags are cleared.
- R8: `line_lvl` follows `rxd` two clocks later, including during a break.
- R9: While `en`=0, frames change no output.
- R10: A low pulse shorter than half a bit time is not taken as a start bit.
- R11: A pulse on `rdy_clr`, `ovr_clr` or `frm_clr` clears that flag. A pulse on `en_wr` loads `en_val` into `en`. A pulse on `id_arm` sets `id_wait`.
- R12: After a matching address, payload frames with flag bit 0 are delivered with `id_wait`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| en_wr | input | 1 | Strobe that loads `en_val` into `en` |
| en_val | input | 1 | New value for `en` |
| id_arm | input | 1 | Strobe that sets `id_wait` |
| rdy_clr | input | 1 | Strobe that clears `ready` |
| ovr_clr | input | 1 | Strobe that clears `ovr_err` |
| frm_clr | input | 1 | Strobe that clears `frm_err` |
| en | output | 1 | Receiver enabled |
| id_wait | output | 1 | Address filter armed |
| ready | output | 1 | New frame held in `rx_byte` |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| rx_byte | output | DBITS | Received payload |
| rx_flag | output | 1 | Flag bit of the held frame |
| line_lvl | output | 1 | Synchronised line level |

## Verification
The assertions assume that a clear strobe never arrives in the same cycle as a frame completion. They also assume that `rxd` keeps each bit for the full bit time, so that only a completed stop sample can change the status flags. The stimulus follows both rules: it issues strobes only while the line is idle, and it drives every bit for exactly 16*DIV clocks. A reference model advances only between frames, and it is compared with the outputs on every clock whenever no frame is in flight.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DIV   = 4,
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             id_arm,
  input  logic             rdy_clr,
  input  logic             ovr_clr,
  input  logic             frm_clr,
  output logic             en,
  output logic             id_wait,
  output logic             ready,
  output logic             ovr_err,
  output logic             frm_err,
  output logic [DBITS-1:0] rx_byte,
  output logic             rx_flag,
  output logic             line_lvl
);
  localparam int NB  = DBITS + 1;
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SW  = $clog2(OSR);
  localparam int BW  = $clog2(NB);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t            st;
  logic [DCW-1:0] pc;
  logic [SW-1:0]  sub;
  logic [BW-1:0]  bitn;
  logic [NB-1:0]  shreg;
  logic [1:0]     rsync;
  logic           rx_s, tick, rx_on, done, drop;

  assign rx_s     = rsync[1];
  assign line_lvl = rx_s;
  assign tick     = (pc == DCW'(DIV - 1));
  assign rx_on    = en & ~ovr_err & ~frm_err;
  assign done     = rx_on & tick & (st == S_STOP) & (sub == SW'(OSR - 1));
  assign drop     = id_wait & ~shreg[NB-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsync <= 2'b11;
      pc    <= '0;
    end else begin
      rsync <= {rsync[0], rxd};
      pc    <= tick ? '0 : pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (!rx_on) begin
      st <= S_IDLE;
    end else if (tick) begin
      case (st)
        S_IDLE: if (!rx_s) begin
          st  <= S_START;
          sub <= '0;
        end
        S_START: if (sub == SW'(OSR / 2 - 1)) begin
          sub  <= '0;
          bitn <= '0;
          st   <= rx_s ? S_IDLE : S_BITS;
        end else sub <= sub + 1'b1;
        S_BITS: if (sub == SW'(OSR - 1)) begin
          sub   <= '0;
          shreg <= {rx_s, shreg[NB-1:1]};
          if (bitn == BW'(NB - 1)) st <= S_STOP;
          else bitn <= bitn + 1'b1;
        end else sub <= sub + 1'b1;
        S_STOP: if (sub == SW'(OSR - 1)) st <= S_IDLE;
                else sub <= sub + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      id_wait <= 1'b0;
      ready   <= 1'b0;
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
      rx_byte <= '0;
      rx_flag <= 1'b0;
    end else begin
      if (en_wr)   en      <= en_val;
      if (id_arm)  id_wait <= 1'b1;
      if (rdy_clr) ready   <= 1'b0;
      if (ovr_clr) ovr_err <= 1'b0;
      if (frm_clr) frm_err <= 1'b0;
      if (done && !drop) begin
        if (!rx_s) frm_err <= 1'b1;
        else if (ready) ovr_err <= 1'b1;
        else begin
          rx_byte <= shreg[DBITS-1:0];
          rx_flag <= shreg[NB-1];
          ready   <= 1'b1;
          id_wait <= 1'b0;
        end
      end
    end
  end

  // R2
  load_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(st == S_STOP));
  // R3
  filter_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && drop) |=> ($stable(rx_byte) && $stable(rx_flag)));
  // R4
  id_auto_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_wait) |-> ready);
  // R5
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $stable(rx_byte));
  // R7
  frozen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err || frm_err) |=> (st == S_IDLE));
  // R9
  disabled_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(ready));
endmodule

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int BITCLK = 16 * DIV;
  localparam logic [7:0] OWN_ID = 8'h42;

  logic clk = 0, rst_n = 0, rxd = 1;
  logic en_wr = 0, en_val = 0, id_arm = 0, rdy_clr = 0, ovr_clr = 0, frm_clr = 0;
  logic en, id_wait, ready, ovr_err, frm_err, rx_flag, line_lvl;
  logic [7:0] rx_byte;

  int total = 0, bad = 0;
  bit chk_on = 0;
  string cur_req = "R1";
  logic e_en = 0, e_idw = 0, e_rdy = 0, e_ovr = 0, e_frm = 0, e_flag = 0;
  logic [7:0] e_byte = 0;

  mp_uart_rx #(.DIV(DIV)) i_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .en_wr(en_wr), .en_val(en_val),
    .id_arm(id_arm), .rdy_clr(rdy_clr), .ovr_clr(ovr_clr), .frm_clr(frm_clr),
    .en(en), .id_wait(id_wait), .ready(ready), .ovr_err(ovr_err),
    .frm_err(frm_err), .rx_byte(rx_byte), .rx_flag(rx_flag), .line_lvl(line_lvl));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    logic [13:0] a, e;
    a = {en, id_wait, ready, ovr_err, frm_err, rx_flag, rx_byte};
    e = {e_en, e_idw, e_rdy, e_ovr, e_frm, e_flag, e_byte};
    chk(a == e, cur_req, int'(a), int'(e));
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_en(input logic v);
    step(1); en_wr = 1; en_val = v;
    step(1); en_wr = 0; e_en = v;
  endtask

  task automatic arm_id();
    step(1); id_arm = 1;
    step(1); id_arm = 0; e_idw = 1;
  endtask

  task automatic clear(input bit r, input bit o, input bit f);
    step(1); rdy_clr = r; ovr_clr = o; frm_clr = f;
    step(1); rdy_clr = 0; ovr_clr = 0; frm_clr = 0;
    if (r) e_rdy = 0;
    if (o) e_ovr = 0;
    if (f) e_frm = 0;
  endtask

  function automatic void model_frame(input logic [7:0] d, input logic fl, input logic stop);
    if (!e_en || e_ovr || e_frm) return;
    if (e_idw && !fl) return;
    if (!stop) e_frm = 1;
    else if (e_rdy) e_ovr = 1;
    else begin
      e_byte = d; e_flag = fl; e_rdy = 1; e_idw = 0;
    end
  endfunction

  task automatic send(input logic [7:0] d, input logic fl, input logic stop, input string req);
    logic [10:0] fr;
    cur_req = req;
    chk_on = 0;
    fr = {stop, fl, d, 1'b0};
    step(1);
    for (int i = 0; i < 11; i++) begin
      rxd = fr[i];
      step(BITCLK);
    end
    rxd = 1;
    model_frame(d, fl, stop);
    step(BITCLK);
    chk_on = 1;
    step(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk({en, id_wait, ready, ovr_err, frm_err, rx_flag, rx_byte} == 14'd0, "R1",
        int'({en, id_wait, ready, ovr_err, frm_err, rx_flag, rx_byte}), 0);
    cur_req = "R1"; chk_on = 1; step(3);

    cur_req = "R11"; set_en(1);
    chk(en == 1, "R11", en, 1);
    send(8'h5A, 0, 1, "R2");
    chk(ready == 1 && rx_byte == 8'h5A && rx_flag == 0, "R2", rx_byte, 8'h5A);
    cur_req = "R11"; clear(1, 0, 0);

    // R12 / R3 / R4 address filtering
    arm_id();
    chk(id_wait == 1, "R11", id_wait, 1);
    send(8'h11, 0, 1, "R3");
    chk(ready == 0 && rx_byte == 8'h5A, "R3", rx_byte, 8'h5A);
    send(8'h33, 1, 1, "R4");
    chk(ready == 1 && id_wait == 0 && rx_byte == 8'h33 && rx_flag == 1, "R4", rx_byte, 8'h33);
    if (rx_byte != OWN_ID) begin clear(1, 0, 0); arm_id(); end
    send(8'h22, 0, 1, "R3");
    chk(ready == 0 && rx_byte == 8'h33, "R3", rx_byte, 8'h33);
    send(OWN_ID, 1, 1, "R4");
    chk(rx_byte == OWN_ID && id_wait == 0, "R4", rx_byte, OWN_ID);
    clear(1, 0, 0);
    send(8'h77, 0, 1, "R12");
    chk(ready == 1 && rx_byte == 8'h77 && id_wait == 0, "R12", rx_byte, 8'h77);

    // R5 overrun
    send(8'h88, 0, 1, "R5");
    chk(ovr_err == 1 && rx_byte == 8'h77 && ready == 1, "R5", rx_byte, 8'h77);
    // R7 frozen by overrun
    send(8'h99, 0, 1, "R7");
    chk(rx_byte == 8'h77 && frm_err == 0, "R7", rx_byte, 8'h77);
    clear(1, 1, 0);
    send(8'hA5, 0, 1, "R7");
    chk(ready == 1 && rx_byte == 8'hA5, "R7", rx_byte, 8'hA5);
    clear(1, 0, 0);

    // R6 framing error
    send(8'h3C, 0, 0, "R6");
    chk(frm_err == 1 && ready == 0 && rx_byte == 8'hA5, "R6", rx_byte, 8'hA5);
    send(8'h55, 0, 1, "R7");
    chk(ready == 0 && rx_byte == 8'hA5, "R7", rx_byte, 8'hA5);
    clear(0, 0, 1);

    // R8 break
    cur_req = "R8"; chk_on = 0;
    step(1); rxd = 0;
    step(22 * BITCLK);
    model_frame(8'h00, 0, 0);
    chk(line_lvl == 0, "R8", line_lvl, 0);
    chk(frm_err == 1, "R6", frm_err, 1);
    rxd = 1;
    step(3);
    chk(line_lvl == 1, "R8", line_lvl, 1);
    step(BITCLK);
    chk_on = 1;
    clear(0, 0, 1);
    send(8'hC3, 0, 1, "R7");
    chk(ready == 1 && rx_byte == 8'hC3, "R7", rx_byte, 8'hC3);
    clear(1, 0, 0);

    // R10 short glitch
    cur_req = "R10";
    step(1); rxd = 0;
    step(3 * DIV); rxd = 1;
    step(2 * BITCLK);
    chk(ready == 0 && frm_err == 0 && rx_byte == 8'hC3, "R10", rx_byte, 8'hC3);
    send(8'h0F, 0, 1, "R10");
    chk(rx_byte == 8'h0F, "R10", rx_byte, 8'h0F);
    clear(1, 0, 0);

    // R9 disabled
    set_en(0);
    send(8'hF0, 0, 1, "R9");
    chk(ready == 0 && rx_byte == 8'h0F, "R9", rx_byte, 8'h0F);

    chk_on = 0;
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule